// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external processor use an 8-bit bus to read and write one data register inside the chip. The external side has three active-low controls: chip select, read strobe and write strobe. The block reacts to them only while a port-enable bit is set and the direction bits of all three control pins mark them as inputs. The internal side of the chip writes and reads the same register through a plain single-cycle strobe interface.

The external handshake has no timing relationship to the system clock. The chip-select, write-strobe and data-pin inputs pass through a synchronizer and an edge detector. An external write takes effect when the write strobe goes back high while chip select is low. The bus output enable is the exception: it is decoded directly from the raw pins, so the register drives the bus as soon as the master asks for a read.

Three status flags follow the traffic. The input-full flag means the external master has written a byte that the internal side has not yet read. The output-full flag means the internal side has written a byte that the master has not yet read. The overflow flag means the master wrote again while the input-full flag was still set.

Top module: `pslv_port`

## Requirements
- R1: After reset, `cpu_rdata` is 0x00, `ibf`, `obf` and `ovf` are 0, and `pin_oe` is 0.
- R2: With the port active, a write pulse (`wr_n` low then high) during which `cs_n` is low latches the value held on `pin_in` into the data register, which appears on `cpu_rdata`. The same write sets `ibf`.
- R3: With the port active, `pin_oe` is 1 and `pin_out` equals the data register while `rd_n` and `cs_n` are both 0. `pin_oe` returns to 0 once `rd_n` goes back to 1.
- R4: While `cs_n` is 1, the strobes have no effect: the register keeps its value, no flag changes and `pin_oe` stays 0.
- R5: The port is active only when `mode_en` is 1 and all three bits of `ctl_dir` are 1. When it is inactive, external strobes change neither the register nor the flags, and `pin_oe` stays 0.
- R6: A one-cycle pulse on `cpu_rd` clears `ibf`.
- R7: A one-cycle pulse on `cpu_wr` loads `cpu_wdata` into the data register and sets `obf`. A completed external read (`rd_n` rising while `cs_n` is low) clears `obf`.
- R8: An external write that arrives while `ibf` is 1, with no `cpu_rd` in the same cycle, sets `ovf` and still stores the new byte. `ovf` stays set until the port becomes inactive, and reads 0 while the port is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Port enable bit |
| ctl_dir | input | 3 | Direction bits of the control pins; 1 means input |
| cs_n | input | 1 | External chip select, active low |
| rd_n | input | 1 | External read strobe, active low |
| wr_n | input | 1 | External write strobe, active low |
| pin_in | input | 8 | Data bus as seen at the pins |
| pin_out | output | 8 | Data driven onto the bus during a read |
| pin_oe | output | 1 | Bus output enable |
| cpu_wr | input | 1 | Internal write strobe |
| cpu_wdata | input | 8 | Internal write data |
| cpu_rd | input | 1 | Internal read strobe; clears the input-full flag |
| cpu_rdata | output | 8 | Current contents of the data register |
| ibf | output | 1 | Input-full flag |
| obf | output | 1 | Output-full flag |
| ovf | output | 1 | Overflow flag |

## Verification
The data register is always visible on `cpu_rdata`, so a capture on the wrong edge, or a stale pipeline stage of the pin data, shows up a few cycles after the write strobe is released. A flag that sets on the wrong event, or fails to clear, is visible on its own output within three cycles of the event that should have moved it. An output-enable fault is visible at once, because that decode is combinational from the pins. Stray writes with chip select high or with the port inactive are caught through `cpu_rdata` and `ibf` before the next valid transfer overwrites the evidence.

// File: rtl/pslv_pkg.sv
package pslv_pkg;
  localparam int CTL_N = 3;

  // Completion of an active-low strobe while selected in the cycle before
  function automatic logic strobe_done(logic prev_n, logic cur_n, logic sel_prev_n);
    return !prev_n && cur_n && !sel_prev_n;
  endfunction

  // Port is usable only with the enable set and every control pin an input
  function automatic logic port_ready(logic en, logic [CTL_N-1:0] dir);
    return en && (&dir);
  endfunction

  // Set has priority over clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pslv_strobe.sv
module pslv_strobe #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          cs_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic [DW-1:0] din_s,
  output logic          wr_evt,
  output logic          rd_evt,
  output logic [DW-1:0] wdata
);
  import pslv_pkg::*;

  logic          cs_q, rd_q, wr_q;
  logic [DW-1:0] din_q;

  // One more stage so the captured data lines up with the last low cycle of the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      din_q <= '0;
    end else begin
      cs_q  <= cs_s;
      rd_q  <= rd_s;
      wr_q  <= wr_s;
      din_q <= din_s;
    end
  end

  assign wr_evt = active && strobe_done(wr_q, wr_s, cs_q);
  assign rd_evt = active && strobe_done(rd_q, rd_s, cs_q);
  assign wdata  = din_q;
endmodule

// File: rtl/pslv_flags.sv
module pslv_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wr_evt,
  input  logic rd_evt,
  input  logic cpu_wr,
  input  logic cpu_rd,
  output logic ibf,
  output logic obf,
  output logic ovf
);
  import pslv_pkg::*;

  logic ovf_hit;
  assign ovf_hit = wr_evt && ibf && !cpu_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf <= 1'b0;
      obf <= 1'b0;
      ovf <= 1'b0;
    end else begin
      ibf <= flag_next(ibf, wr_evt, cpu_rd);
      obf <= flag_next(obf, cpu_wr, rd_evt);
      ovf <= active ? flag_next(ovf, ovf_hit, 1'b0) : 1'b0;
    end
  end

  assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> $past(wr_evt));
  assert_ibf_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf) |-> $past(cpu_rd));
  assert_obf_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf) |-> $past(rd_evt));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(ibf));
  assert_ovf_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ovf);
endmodule

// File: rtl/pslv_port.sv
module pslv_port #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_en,
  input  logic [pslv_pkg::CTL_N-1:0] ctl_dir,
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic                       wr_n,
  input  logic [DW-1:0]              pin_in,
  output logic [DW-1:0]              pin_out,
  output logic                       pin_oe,
  input  logic                       cpu_wr,
  input  logic [DW-1:0]              cpu_wdata,
  input  logic                       cpu_rd,
  output logic [DW-1:0]              cpu_rdata,
  output logic                       ibf,
  output logic                       obf,
  output logic                       ovf
);
  import pslv_pkg::*;

  localparam int CW = CTL_N;

  logic          active;
  logic [CW-1:0] ctl_s;
  logic [DW-1:0] din_s;
  logic          wr_evt, rd_evt;
  logic [DW-1:0] ext_wdata;
  logic [DW-1:0] data_q;

  assign active = port_ready(mode_en, ctl_dir);

  pslv_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL({CW{1'b1}})) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rd_n, wr_n}), .q(ctl_s)
  );

  pslv_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_s)
  );

  pslv_strobe #(.DW(DW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .active(active),
    .cs_s(ctl_s[2]), .rd_s(ctl_s[1]), .wr_s(ctl_s[0]), .din_s(din_s),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .wdata(ext_wdata)
  );

  pslv_flags u_flags (
    .clk(clk), .rst_n(rst_n), .active(active),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .ibf(ibf), .obf(obf), .ovf(ovf)
  );

  // External write has priority over an internal write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (wr_evt) data_q <= ext_wdata;
    else if (cpu_wr) data_q <= cpu_wdata;
  end

  assign pin_oe    = active && !rd_n && !cs_n;
  assign pin_out   = data_q;
  assign cpu_rdata = data_q;

  assert_data_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(wr_evt || cpu_wr));
  assert_oe_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (!cs_n && !rd_n));
  assert_oe_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> mode_en);
  assert_wr_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> active);
endmodule

// File: tb/pslv_port_tb.sv
`timescale 1ns/1ps
module pslv_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_en = 1'b0;
  logic [2:0] ctl_dir = 3'b000;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out;
  logic       pin_oe;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       ibf, obf, ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pslv_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .ctl_dir(ctl_dir),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .ibf(ibf), .obf(obf), .ovf(ovf)
  );

  // {op, din, expected data, ibf, obf, ovf}; op 0 ext write, 1 ext read, 2 cpu write, 3 cpu read
  localparam logic [20:0] VEC [9] = '{
    {2'd0, 8'hA5, 8'hA5, 3'b100},
    {2'd3, 8'h00, 8'hA5, 3'b000},
    {2'd2, 8'h3C, 8'h3C, 3'b010},
    {2'd1, 8'h00, 8'h3C, 3'b000},
    {2'd0, 8'h11, 8'h11, 3'b100},
    {2'd0, 8'h22, 8'h22, 3'b101},
    {2'd3, 8'h00, 8'h22, 3'b001},
    {2'd2, 8'h7E, 8'h7E, 3'b011},
    {2'd1, 8'h00, 8'h7E, 3'b001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_write(input logic [7:0] d, input logic sel_n);
    @(negedge clk); pin_in = d; cs_n = sel_n;
    cyc(1); wr_n = 1'b0;
    cyc(3); wr_n = 1'b1;
    cyc(2); cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic ext_read(input logic [7:0] exp, input logic sel_n, input logic exp_oe,
                          input string req);
    @(negedge clk); cs_n = sel_n; rd_n = 1'b0;
    cyc(2);
    chk({req, " oe during read"}, pin_oe, exp_oe);
    if (exp_oe) chk({req, " pin_out"}, pin_out, exp);
    rd_n = 1'b1;
    cyc(1);
    chk("R3 oe released", pin_oe, 1'b0);
    cyc(1); cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic cpu_op(input logic is_wr, input logic [7:0] d);
    @(negedge clk);
    if (is_wr) begin cpu_wr = 1'b1; cpu_wdata = d; end
    else cpu_rd = 1'b1;
    cyc(1); cpu_wr = 1'b0; cpu_rd = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 data", cpu_rdata, 8'h00);
    chk("R1 ibf", ibf, 1'b0);
    chk("R1 obf", obf, 1'b0);
    chk("R1 ovf", ovf, 1'b0);
    chk("R1 oe", pin_oe, 1'b0);

    mode_en = 1'b1; ctl_dir = 3'b111;
    cyc(2);
    for (int i = 0; i < 9; i++) begin
      logic [20:0] v;
      v = VEC[i];
      case (v[20:19])
        2'd0: ext_write(v[18:11], 1'b0);
        2'd1: ext_read(v[10:3], 1'b0, 1'b1, "R3");
        2'd2: cpu_op(1'b1, v[18:11]);
        default: cpu_op(1'b0, 8'h00);
      endcase
      chk("R2/R7 data", cpu_rdata, v[10:3]);
      chk("R2/R6 ibf", ibf, v[2]);
      chk("R7 obf", obf, v[1]);
      chk("R8 ovf", ovf, v[0]);
    end

    // Port disabled: overflow clears, strobes ignored
    @(negedge clk); mode_en = 1'b0;
    cyc(2);
    chk("R8 ovf cleared when inactive", ovf, 1'b0);
    ext_write(8'h99, 1'b0);
    chk("R5 data kept, mode off", cpu_rdata, 8'h7E);
    chk("R5 ibf kept, mode off", ibf, 1'b0);
    ext_read(8'h7E, 1'b0, 1'b0, "R5 mode off");

    // Enabled but one control pin not an input
    @(negedge clk); mode_en = 1'b1; ctl_dir = 3'b101;
    ext_write(8'h55, 1'b0);
    chk("R5 data kept, dir bit clear", cpu_rdata, 8'h7E);
    chk("R5 ibf kept, dir bit clear", ibf, 1'b0);
    ext_read(8'h7E, 1'b0, 1'b0, "R5 dir bit clear");

    // Fully enabled, chip not selected
    @(negedge clk); ctl_dir = 3'b111;
    cpu_op(1'b1, 8'h42);
    ext_write(8'hC3, 1'b1);
    chk("R4 data kept, cs high", cpu_rdata, 8'h42);
    chk("R4 ibf kept, cs high", ibf, 1'b0);
    ext_read(8'h42, 1'b1, 1'b0, "R4 cs high");
    chk("R4 obf kept, cs high", obf, 1'b1);
    chk("R4 ovf kept, cs high", ovf, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule